// File: doc/BRIEF.md
# Two-Grid Fluorescent Display Scan and Brightness Controller

This block drives a vacuum fluorescent display that has 30 segment lines and two grids, scanned at 1/2 duty. A host writes 64-bit frames over a three-wire serial link made of a select line, a data line and a clock line. The serial pins are sampled by the block's own reference clock, so the host's serial clock must run slower than the reference clock. Two kinds of frame exist. A display frame holds the segment pattern for both grids. A control frame holds an 11-bit brightness word and a bit that picks the brightness source. When the select line falls, the block latches the shifted frame. The bit that left the far end of the shift register appears on a serial output, so further drivers can be chained behind this one.

The scan engine alternates the two grids. Each grid period opens with a short dark gap, followed by a lit window of 2^11 reference clocks. Inside that window, the grid and its segments stay lit for a number of clocks taken from one of three sources. The first is the latched brightness word. The second is the measured duty of an external PWM input, scaled to 11 bits. The third is full brightness, used whenever the daylight input is high. A low level on the blank input darkens every output.

Top module: `vfd_scan_top`

## Requirements
- R1: Serial clock edges that arrive while the select input is low shift nothing: the serial output and the latched display and brightness state stay unchanged.
- R2: While select is high, each rising edge of the serial clock shifts the data bit into the least significant end of a 64-bit register. The first bit sent therefore ends in bit 63 after 64 edges.
- R3: The serial output is bit 63 of the shift register, so it carries the bit that entered 64 serial clocks earlier.
- R4: The falling edge of select latches the register. If bit 63 is 0, bits 29:0 become the segment pattern for grid 0 and bits 59:30 become the pattern for grid 1. If bit 63 is 1, bits 10:0 become the brightness word and bit 11 picks the source (1 = PWM input, 0 = brightness word). All other bits are ignored.
- R5: The grids take turns, and at most one is driven at a time. Each grid period is 4 dark reference clocks followed by a 2048-clock lit window, so one grid's last lit cycle and the other grid's first lit cycle are exactly 4 dark cycles apart.
- R6: When the brightness word is the source and daylight is low, each grid is lit for exactly as many clocks per period as the brightness word holds (0 to 2047).
- R7: When the PWM input is the source and daylight is low, the lit clocks per grid period equal floor(H*2048/P). Here H is the high time and P is the period of the PWM input, both counted in reference clocks over one PWM period.
- R8: When daylight is high, each grid is lit for all 2048 clocks of its window, whichever source is selected.
- R9: One clock after the blank input is sampled low, every segment and grid output is low.
- R10: After reset, all outputs are low, both segment patterns are zero, the brightness word is 0 and the brightness word is the source. A display brought up without daylight therefore stays dark.
- R11: A segment output is high only while its grid is driven, and then it carries that grid's latched pattern bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for scanning, sampling and dimming |
| rstN | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Serial select; high enables shifting, falling edge latches |
| sClkIn | input | 1 | Serial shift clock, rising edge active |
| sDataIn | input | 1 | Serial data, most significant frame bit first |
| pwmIn | input | 1 | External PWM brightness input |
| daylightIn | input | 1 | High forces full lit time per grid |
| blankN | input | 1 | Low darkens every output |
| serOut | output | 1 | Cascade serial output, 64 bits behind the input |
| segOut | output | 30 | Segment drive for the grid being scanned |
| gridOut | output | 2 | Grid drive, bit 0 for grid 0 and bit 1 for grid 1 |

## Verification
If the shift register or the frame latch goes wrong, the fault shows up as a wrong segment pattern within one grid period of the select falling. It also shows up on the serial output during the very next frame that is shifted through. If the scan counter or the lit-time snapshot goes wrong, the number of lit clocks per grid changes, or the gap between grids shrinks. This can be seen by counting lit cycles over one full two-grid frame of 4104 clocks. If the PWM measurement or the divider goes wrong, the lit count moves away from floor(H*2048/P) within about two PWM periods plus one grid period.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
  localparam int FRAME_W = 64;
  localparam int SEG_N = 30;
  // Frame type lives in the first bit sent.
  localparam logic FRAME_DISPLAY = 1'b0;
  localparam logic FRAME_CONTROL = 1'b1;

  typedef enum logic {PH_GAP, PH_LIT} scan_phase_e;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic shiftEn;   // one serial bit accepted
    logic shiftBit;  // its value
    logic latchEn;   // select fell: capture the frame
    logic pwmLvl;    // synchronized PWM level
    logic pwmRise;   // PWM rising edge
    logic snapEn;    // last gap cycle: capture the lit time
    logic lit;       // lit window active
    logic gridSel;   // grid being scanned
  } ctl_strobe_t;
endpackage

// File: rtl/vfd_duty_div.sv
// Shift-subtract divider: quotient = floor(highCnt * 2^DIM_BITS / perCnt).
// Needs highCnt <= perCnt and takes DIM_BITS+1 cycles.
module vfd_duty_div #(
  parameter int CNT_W = 16,
  parameter int DIM_BITS = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [CNT_W-1:0]    highCnt,
  input  logic [CNT_W-1:0]    perCnt,
  output logic [DIM_BITS:0]   dutyVal
);
  localparam int STEP_W = $clog2(DIM_BITS + 1);

  logic [CNT_W:0]    rem;
  logic [CNT_W-1:0]  divisor;
  logic [DIM_BITS:0] quo;
  logic [STEP_W-1:0] stepCnt;
  logic              busy;
  logic              geq;
  logic [CNT_W:0]    remSub;

  assign geq    = rem >= {1'b0, divisor};
  assign remSub = geq ? (rem - {1'b0, divisor}) : rem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem     <= '0;
      divisor <= '0;
      quo     <= '0;
      stepCnt <= '0;
      busy    <= 1'b0;
      dutyVal <= '0;
    end else if (start) begin
      rem     <= {1'b0, highCnt};
      divisor <= perCnt;
      quo     <= '0;
      stepCnt <= STEP_W'(DIM_BITS);
      busy    <= 1'b1;
    end else if (busy) begin
      rem <= {remSub[CNT_W-1:0], 1'b0};
      quo <= {quo[DIM_BITS-1:0], geq};
      if (stepCnt == '0) begin
        busy    <= 1'b0;
        dutyVal <= {quo[DIM_BITS-1:0], geq};
      end else begin
        stepCnt <= stepCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/vfd_scan_ctrl.sv
// Control: synchronizes the pins, finds their edges and runs the grid scan timer.
module vfd_scan_ctrl
  import vfd_scan_pkg::*;
#(
  parameter int DIM_BITS = 11,
  parameter int GAP_TICKS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csIn,
  input  logic                sClkIn,
  input  logic                sDataIn,
  input  logic                pwmIn,
  output ctl_strobe_t         strobe,
  output logic [DIM_BITS-1:0] phaseCnt
);
  localparam int GAP_W = $clog2(GAP_TICKS + 1);
  localparam int PIN_N = 4;

  logic [PIN_N-1:0] syncPipe [SYNC_STAGES];
  logic [PIN_N-1:0] pinS;
  logic csD, sClkD, pwmD;
  logic csS, sClkS, sDataS, pwmS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= '0;
    end else begin
      syncPipe[0] <= {pwmIn, sDataIn, sClkIn, csIn};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign pinS   = syncPipe[SYNC_STAGES-1];
  assign csS    = pinS[0];
  assign sClkS  = pinS[1];
  assign sDataS = pinS[2];
  assign pwmS   = pinS[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD   <= 1'b0;
      sClkD <= 1'b0;
      pwmD  <= 1'b0;
    end else begin
      csD   <= csS;
      sClkD <= sClkS;
      pwmD  <= pwmS;
    end
  end

  // Grid scan timer.
  scan_phase_e      phase;
  logic [GAP_W-1:0] gapCnt;
  logic             gridSel;
  logic             gapLast;
  logic             litLast;

  assign gapLast = (phase == PH_GAP) && (gapCnt == GAP_W'(GAP_TICKS - 1));
  assign litLast = (phase == PH_LIT) && (phaseCnt == {DIM_BITS{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_GAP;
      gapCnt   <= '0;
      phaseCnt <= '0;
      gridSel  <= 1'b0;
    end else if (phase == PH_GAP) begin
      if (gapLast) begin
        phase    <= PH_LIT;
        gapCnt   <= '0;
        phaseCnt <= '0;
      end else begin
        gapCnt <= gapCnt + 1'b1;
      end
    end else begin
      if (litLast) begin
        phase   <= PH_GAP;
        gridSel <= ~gridSel;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.shiftEn  = csS & sClkS & ~sClkD;
    strobe.shiftBit = sDataS;
    strobe.latchEn  = csD & ~csS;
    strobe.pwmLvl   = pwmS;
    strobe.pwmRise  = pwmS & ~pwmD;
    strobe.snapEn   = gapLast;
    strobe.lit      = (phase == PH_LIT);
    strobe.gridSel  = gridSel;
  end
endmodule

// File: rtl/vfd_scan_dp.sv
// Datapath: shift register, frame latches, PWM measurement, lit-time snapshot, output registers.
module vfd_scan_dp
  import vfd_scan_pkg::*;
#(
  parameter int DIM_BITS = 11,
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_strobe_t         strobe,
  input  logic [DIM_BITS-1:0] phaseCnt,
  input  logic                daylightIn,
  input  logic                blankN,
  output logic                serOut,
  output logic [SEG_N-1:0]    segOut,
  output logic [1:0]          gridOut
);
  localparam int SRC_BIT = DIM_BITS;
  localparam logic [DIM_BITS:0] FULL_ON = 1 << DIM_BITS;

  logic [FRAME_W-1:0]   shiftReg;
  logic [2*SEG_N-1:0]   segLatch;
  logic [DIM_BITS-1:0]  dimWord;
  logic                 srcPwm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], strobe.shiftBit};
    end
  end
  assign serOut = shiftReg[FRAME_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segLatch <= '0;
      dimWord  <= '0;
      srcPwm   <= 1'b0;
    end else if (strobe.latchEn) begin
      if (shiftReg[FRAME_W-1] == FRAME_CONTROL) begin
        dimWord <= shiftReg[DIM_BITS-1:0];
        srcPwm  <= shiftReg[SRC_BIT];
      end else begin
        segLatch <= shiftReg[2*SEG_N-1:0];
      end
    end
  end

  // PWM measurement over one input period.
  logic [CNT_W-1:0] highCnt, perCnt;
  logic             seenEdge;
  logic [DIM_BITS:0] pwmDuty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt  <= '0;
      perCnt   <= '0;
      seenEdge <= 1'b0;
    end else if (strobe.pwmRise) begin
      highCnt  <= CNT_W'(1);
      perCnt   <= CNT_W'(1);
      seenEdge <= 1'b1;
    end else begin
      if (perCnt != {CNT_W{1'b1}}) perCnt <= perCnt + 1'b1;
      if (strobe.pwmLvl && highCnt != {CNT_W{1'b1}}) highCnt <= highCnt + 1'b1;
    end
  end

  vfd_duty_div #(.CNT_W(CNT_W), .DIM_BITS(DIM_BITS)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .start   (strobe.pwmRise & seenEdge),
    .highCnt (highCnt),
    .perCnt  (perCnt),
    .dutyVal (pwmDuty)
  );

  // Lit time is frozen for a whole grid period.
  logic [DIM_BITS:0] onSnap;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onSnap <= '0;
    end else if (strobe.snapEn) begin
      if (daylightIn)  onSnap <= FULL_ON;
      else if (srcPwm) onSnap <= pwmDuty;
      else             onSnap <= {1'b0, dimWord};
    end
  end

  logic litOn;
  assign litOn = strobe.lit && blankN && ({1'b0, phaseCnt} < onSnap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gridOut <= '0;
      segOut  <= '0;
    end else if (!litOn) begin
      gridOut <= '0;
      segOut  <= '0;
    end else if (strobe.gridSel) begin
      gridOut <= 2'b10;
      segOut  <= segLatch[2*SEG_N-1:SEG_N];
    end else begin
      gridOut <= 2'b01;
      segOut  <= segLatch[SEG_N-1:0];
    end
  end
endmodule

// File: rtl/vfd_scan_top.sv
module vfd_scan_top
  import vfd_scan_pkg::*;
#(
  parameter int DIM_BITS = 11,
  parameter int GAP_TICKS = 4,
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csIn,
  input  logic             sClkIn,
  input  logic             sDataIn,
  input  logic             pwmIn,
  input  logic             daylightIn,
  input  logic             blankN,
  output logic             serOut,
  output logic [SEG_N-1:0] segOut,
  output logic [1:0]       gridOut
);
  ctl_strobe_t         strobe;
  logic [DIM_BITS-1:0] phaseCnt;

  vfd_scan_ctrl #(
    .DIM_BITS(DIM_BITS), .GAP_TICKS(GAP_TICKS), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sClkIn(sClkIn), .sDataIn(sDataIn),
    .pwmIn(pwmIn), .strobe(strobe), .phaseCnt(phaseCnt)
  );

  vfd_scan_dp #(.DIM_BITS(DIM_BITS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phaseCnt(phaseCnt),
    .daylightIn(daylightIn), .blankN(blankN), .serOut(serOut),
    .segOut(segOut), .gridOut(gridOut)
  );
endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk
  import vfd_scan_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             blankN,
  input logic             shiftEn,
  input logic             serOut,
  input logic [SEG_N-1:0] segOut,
  input logic [1:0]       gridOut
);
  assert_one_grid_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gridOut));

  assert_gap_after_g0_R5: assert property (@(posedge clk) disable iff (!rstN)
    gridOut[0] |=> !gridOut[1]);

  assert_gap_after_g1_R5: assert property (@(posedge clk) disable iff (!rstN)
    gridOut[1] |=> !gridOut[0]);

  assert_seg_needs_grid_R11: assert property (@(posedge clk) disable iff (!rstN)
    (gridOut == 2'b00) |-> (segOut == '0));

  assert_blank_dark_R9: assert property (@(posedge clk) disable iff (!rstN)
    !blankN |=> (gridOut == 2'b00 && segOut == '0));

  assert_cascade_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> $stable(serOut));
endmodule

bind vfd_scan_top vfd_scan_chk u_chk (
  .clk(clk), .rstN(rstN), .blankN(blankN), .shiftEn(strobe.shiftEn),
  .serOut(serOut), .segOut(segOut), .gridOut(gridOut)
);

// File: tb/sim_vfd_scan_top.sv
`timescale 1ns/1ps
module sim_vfd_scan_top;
  localparam int GAP = 4;
  localparam int FULL = 2048;
  localparam int FRAME_CYC = 2 * (GAP + FULL);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0, sClkIn = 1'b0, sDataIn = 1'b0;
  logic pwmIn = 1'b0, daylightIn = 1'b0, blankN = 1'b1;
  logic serOut;
  logic [29:0] segOut;
  logic [1:0] gridOut;

  int checks = 0, errors = 0;
  int pwmP = 0, pwmH = 0;
  bit done = 1'b0;
  logic [63:0] shModel = '0;

  always #2 clk = ~clk;

  vfd_scan_top u0 (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sClkIn(sClkIn), .sDataIn(sDataIn),
    .pwmIn(pwmIn), .daylightIn(daylightIn), .blankN(blankN),
    .serOut(serOut), .segOut(segOut), .gridOut(gridOut)
  );

  function automatic int pwmExp(int h, int p);
    return (h * FULL) / p;
  endfunction

  function automatic logic [63:0] dispFrame(logic [29:0] s0, logic [29:0] s1);
    return {1'b0, 3'($urandom), s1, s0};
  endfunction

  function automatic logic [63:0] ctrlFrame(bit src, int dim);
    return {1'b1, 51'({$urandom, $urandom}), src, 11'(dim)};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  // R2/R3: MSB first; before each edge serOut shows the older frame's bit.
  task automatic sendFrame(logic [63:0] f);
    int bad = 0;
    csIn = 1'b1;
    waitClk(4);
    for (int i = 0; i < 64; i++) begin
      sDataIn = f[63-i];
      waitClk(4);
      if (serOut !== shModel[63-i]) bad++;
      sClkIn = 1'b1;
      waitClk(4);
      sClkIn = 1'b0;
    end
    waitClk(4);
    csIn = 1'b0;
    waitClk(8);
    check(bad == 0, "R3 cascade bits", bad, 0);
    shModel = f;
  endtask

  task automatic measure(string req, int expOn, logic [29:0] s0, logic [29:0] s1, bit chkGap);
    int on0 = 0, on1 = 0, segBad = 0, lowRun = 0, minGap = 1000000;
    bit seenLit = 1'b0;
    waitClk(FRAME_CYC);
    for (int c = 0; c < FRAME_CYC; c++) begin
      @(negedge clk);
      case (gridOut)
        2'b01: begin on0++; if (segOut !== s0) segBad++; end
        2'b10: begin on1++; if (segOut !== s1) segBad++; end
        2'b00: if (segOut !== '0) segBad++;
        default: segBad++;
      endcase
      if (gridOut == 2'b00) lowRun++;
      else begin
        if (seenLit && lowRun > 0 && lowRun < minGap) minGap = lowRun;
        lowRun = 0;
        seenLit = 1'b1;
      end
    end
    check(on0 == expOn, {req, " grid0 lit"}, on0, expOn);
    check(on1 == expOn, {req, " grid1 lit"}, on1, expOn);
    check(segBad == 0, "R11 segment pattern per grid", segBad, 0);
    if (chkGap) check(minGap == GAP, "R5 dark gap", minGap, GAP);
  endtask

  // PWM stimulus: pwmH high clocks per pwmP clocks.
  initial begin
    forever begin
      if (pwmP == 0) begin
        pwmIn = 1'b0;
        @(negedge clk);
      end else begin
        pwmIn = 1'b1;
        repeat (pwmH) @(negedge clk);
        pwmIn = 1'b0;
        repeat (pwmP - pwmH) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int dummy;
    logic [29:0] s0, s1, sgA, sgB;
    logic sOld;
    dummy = $urandom(32'h5EED_0042);
    waitClk(5);
    // R10: reset state
    check(gridOut == 0 && segOut == 0 && serOut == 0, "R10 reset outputs", {gridOut, segOut}, 0);
    rstN = 1'b1;
    waitClk(2);
    measure("R10 dark after reset", 0, '0, '0, 1'b0);

    // R4 / R6: display frame then digital brightness
    s0 = 30'($urandom); s1 = 30'($urandom);
    sendFrame(dispFrame(s0, s1));
    sendFrame(ctrlFrame(1'b0, 1000));
    measure("R6 word 1000", 1000, s0, s1, 1'b0);
    sendFrame(ctrlFrame(1'b0, 2047));
    measure("R6 word 2047", 2047, s0, s1, 1'b0);

    // R1: clocks with select low shift nothing
    sOld = serOut;
    begin
      int moved = 0;
      for (int i = 0; i < 64; i++) begin
        sDataIn = 1'($urandom);
        waitClk(4);
        sClkIn = 1'b1;
        waitClk(4);
        sClkIn = 1'b0;
        if (serOut !== sOld) moved++;
      end
      check(moved == 0, "R1 serial ignored while deselected", moved, 0);
    end
    measure("R1 state kept", 2047, s0, s1, 1'b0);

    // R8 daylight in word mode, plus R5 gap
    daylightIn = 1'b1;
    measure("R8 daylight word mode", FULL, s0, s1, 1'b1);
    daylightIn = 1'b0;

    // R7 PWM source
    pwmP = 400; pwmH = 100;
    sendFrame(ctrlFrame(1'b1, 5));
    measure("R7 pwm 100/400", pwmExp(100, 400), s0, s1, 1'b0);
    pwmP = 700; pwmH = 300;
    measure("R7 pwm 300/700", pwmExp(300, 700), s0, s1, 1'b0);
    daylightIn = 1'b1;
    measure("R8 daylight pwm mode", FULL, s0, s1, 1'b0);
    daylightIn = 1'b0;
    begin
      int p = $urandom_range(1000, 50);
      int h = $urandom_range(p - 1, 1);
      pwmP = p; pwmH = h;
      measure("R7 pwm random", pwmExp(h, p), s0, s1, 1'b0);
    end

    // R9 blank
    blankN = 1'b0;
    measure("R9 blank", 0, s0, s1, 1'b0);
    blankN = 1'b1;

    // R4 random frames in word mode; the unused control bits are random
    for (int k = 0; k < 2; k++) begin
      int d = $urandom_range(2047, 0);
      sgA = 30'($urandom); sgB = 30'($urandom);
      sendFrame(dispFrame(sgA, sgB));
      sendFrame(ctrlFrame(1'b0, d));
      measure("R4 R6 random frame", d, sgA, sgB, 1'b0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule